// File: doc/BRIEF.md
# Serial Clock-Control Register Slave

This block is the control port of a clock generator. It listens on a two-wire serial bus (SCL and SDA) as a slave with one fixed 7-bit device address. It holds three bytes of control bits that go straight to the clock gating and output logic. The bus pins are brought into the system clock domain through two-flip-flop synchronisers and a glitch filter. START and STOP are found from SDA edges that occur while SCL is high.

A write transaction is laid out as follows: the address byte with the direction bit clear, a command byte whose value is ignored, a byte-count byte, and then data bytes. Data bytes always land in register byte 0, then byte 1, then byte 2. Bytes after the third are acknowledged and thrown away. A read transaction starts with the address byte with the direction bit set. The slave then sends a count byte, then the register bytes in the same order, and pads with 0xFF after the last one. It stops driving the bus when the master answers with a NACK.

Some bits are not plain storage. Two status bits show the live frequency-strap inputs. The PCI-run bit is stored, but its output is ANDed with an external active-low stop pin. Reserved bits always read 0.

Top module: `clkctl_smbus_slave`

## Requirements
- R1: The slave acknowledges only address byte 0xD2 (write) and 0xD3 (read). Any other address byte is not acknowledged. Later bytes are then also not acknowledged and change no register, until the next START.
- R2: In a write, the slave acknowledges the command byte and the byte-count byte. The command byte's value has no effect on which register a data byte reaches.
- R3: In a write, the first, second and third data bytes are stored into register bytes 0, 1 and 2. Each data byte is acknowledged by pulling SDA low during the ninth SCL clock.
- R4: Data bytes after the third are acknowledged and change no register. The last byte-count value received is shown on `byte_count_q`, which is 0 after reset.
- R5: After acknowledging 0xD3, the slave transmits MSB first. It sends the count byte 0x03, then register bytes 0, 1, 2, then 0xFF for every later byte. After a master NACK, `sda_oe` is low.
- R6: Byte 0 bits 3 and 2 read back the live levels of `fs_strap[1]` and `fs_strap[0]`. Writes to those bits have no effect.
- R7: Byte 0 bit 1 is a stored run bit. `pci_run` equals that stored bit ANDed with `pci_stop_n`. Reading byte 0 bit 1 returns this combined value.
- R8: The reserved bits read back 0, and writes to them have no effect. These are byte 0 bits 4 and 0, and byte 1 bits 7, 3 and 0. Byte 2 has no reserved bits.
- R9: The writable bits of each byte are as follows. Byte 0: bit 7 `spread_en`, bit 6 `pd_tristate`, bit 5 `alt_freq_sel`, bit 1 run bit. Byte 1: bit 6 `stop_tristate`, bits 5/4 `free_run[1:0]`, bits 2/1 `ch_en[1:0]`. Byte 2: `aux_ctrl[7:0]`. After reset the stored bytes are 0x02, 0x06 and 0x00. They keep their values across transactions that do not write them.
- R10: A pulse on SCL shorter than `FILTER_LEN` system clocks is ignored and does not shift a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| fs_strap | input | 2 | Frequency-select strap levels, read-only bits 3:2 of byte 0 |
| pci_stop_n | input | 1 | Active-low external PCI stop pin |
| spread_en | output | 1 | Spread-spectrum enable |
| pd_tristate | output | 1 | Power-down mode: 1 floats the CPU outputs |
| alt_freq_sel | output | 1 | Selects the alternate frequency on the shared output |
| pci_run | output | 1 | Stored run bit ANDed with pci_stop_n |
| stop_tristate | output | 1 | CPU-stop mode: 1 floats the CPU outputs |
| free_run | output | 2 | Per-pair keep-running-during-stop enables |
| ch_en | output | 2 | Per-pair output enables |
| aux_ctrl | output | 8 | Byte 2 control bits |
| byte_count_q | output | 8 | Last byte-count value received |

## Verification
The bench probes several corner cases:
- An address that is one bit away from the device address, which a loose comparator would acknowledge and then let write registers.
- A write longer than three bytes, where a design that does not saturate its byte pointer would wrap around onto byte 0.
- A read that runs past the last register, where a design would send stale bytes instead of 0xFF, or keep holding SDA after the master's NACK.
- Strap changes with no write in between, and writes of all ones into reserved and read-only positions, which catch designs that store bits they should only reflect.
- A one-clock SCL dip in the middle of a data bit, which an unfiltered design would count as an extra bit, so the byte would arrive shifted.

// File: rtl/clkctl_pkg.sv
// Package: shared constants and types for the serial clock-control slave.
// Assumes a fixed three-byte register map.
package clkctl_pkg;

    localparam int REG_BYTES = 3;
    localparam int BYTE_W    = 8;

    // Writable-bit masks and reset values per register byte
    localparam logic [BYTE_W-1:0] RW_MASK [REG_BYTES] = '{8'hE2, 8'h76, 8'hFF};
    localparam logic [BYTE_W-1:0] RST_VAL [REG_BYTES] = '{8'h02, 8'h06, 8'h00};

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RX     = 3'd1,
        ST_RX_ACK = 3'd2,
        ST_TX     = 3'd3,
        ST_TX_ACK = 3'd4
    } eng_state_t;

endpackage

// File: rtl/clkctl_line_filter.sv
// Module: two-flip-flop synchroniser followed by a persistence filter.
// The clean output only follows the input after it has held a new level
// for FILT_LEN consecutive system clocks. Idle level of the line is high.
module clkctl_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic          filt_q;
    logic [CW-1:0] run_cnt;

    // Synchronise the line, then accept a new level only once it has persisted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            filt_q  <= 1'b1;
            run_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == filt_q) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(FILT_LEN - 1)) begin
                filt_q  <= sync_q[1];
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign clean = filt_q;

    // A filtered change must follow the synchronised level that preceded it
    assert_filter_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(sync_q[1]) == filt_q));

endmodule

// File: rtl/clkctl_bus_cond.sv
// Module: conditions SCL and SDA and derives bus events.
// Emits one-cycle pulses for SCL rise/fall, START and STOP.
// Assumes SDA only moves while SCL is low, except at START and STOP.
module clkctl_bus_cond #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] raw_v;
    logic [1:0] clean_v;
    logic       scl_f;
    logic       scl_q;
    logic       sda_q;

    assign raw_v = {sda_in, scl_in};

    for (genvar i = 0; i < 2; i++) begin : g_line
        clkctl_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_v[i]),
            .clean (clean_v[i])
        );
    end

    assign scl_f = clean_v[0];
    assign sda_f = clean_v[1];

    // Keep the previous filtered levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  =  scl_f & ~scl_q;
    assign scl_fall  = ~scl_f &  scl_q;
    assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
    assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;

endmodule

// File: rtl/clkctl_serial_engine.sv
// Module: byte-level protocol engine for the slave.
// Handles address match, command/count bytes, sequential data bytes,
// acknowledge generation and read-back transmission.
// Assumes event pulses come from clkctl_bus_cond.
module clkctl_serial_engine
    import clkctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7 = 7'h69,
    parameter int         NUM_BYTES = REG_BYTES,
    parameter logic [7:0] FILL_BYTE = 8'hFF,
    localparam int        IW        = $clog2(NUM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_f,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic [IW-1:0] rd_idx,
    input  logic [7:0]    rd_data,
    output logic [7:0]    count_q
);
    localparam int BW       = $clog2(NUM_BYTES + 4);
    localparam int PW       = $clog2(NUM_BYTES + 1);
    localparam int MAXB     = NUM_BYTES + 3;
    localparam int DATA_POS = 3;

    eng_state_t    state;
    logic [3:0]    bitcnt;
    logic [BW-1:0] byte_num;
    logic [PW-1:0] rd_ptr;
    logic [7:0]    rx_sh;
    logic [7:0]    tx_sh;
    logic          is_read;
    logic [BW-1:0] data_pos;
    logic          data_in_range;
    logic [7:0]    next_tx;
    logic          addr_hit;

    assign data_pos      = byte_num - BW'(DATA_POS);
    assign data_in_range = (byte_num >= BW'(DATA_POS)) && (data_pos < BW'(NUM_BYTES));
    assign rd_idx        = IW'(rd_ptr);
    assign next_tx       = (rd_ptr < PW'(NUM_BYTES)) ? rd_data : FILL_BYTE;
    assign addr_hit      = (rx_sh[7:1] == DEV_ADDR7);

    // Protocol sequencer: bus events drive receive, acknowledge and transmit phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            byte_num <= '0;
            rd_ptr   <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            is_read  <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            count_q  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state    <= ST_RX;
                bitcnt   <= '0;
                byte_num <= '0;
                is_read  <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh  <= {rx_sh[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (byte_num == '0) begin
                                if (addr_hit) begin
                                    is_read <= rx_sh[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_RX_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_RX_ACK;
                                if (byte_num == BW'(2)) begin
                                    count_q <= rx_sh;
                                end
                                if (data_in_range) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= IW'(data_pos);
                                    wr_data <= rx_sh;
                                end
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (byte_num != BW'(MAXB)) begin
                                byte_num <= byte_num + 1'b1;
                            end
                            if (is_read) begin
                                state  <= ST_TX;
                                tx_sh  <= 8'(NUM_BYTES);
                                sda_oe <= ~(8'(NUM_BYTES) >> 7);
                                rd_ptr <= '0;
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                                state  <= ST_TX_ACK;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise && sda_f) begin
                            state <= ST_IDLE;
                        end else if (scl_fall) begin
                            tx_sh  <= next_tx;
                            sda_oe <= ~next_tx[7];
                            state  <= ST_TX;
                            if (rd_ptr < PW'(NUM_BYTES)) begin
                                rd_ptr <= rd_ptr + 1'b1;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // A rejected address leaves the slave silent and idle
    assert_bad_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX && byte_num == '0 && scl_fall && bitcnt == 4'd8 &&
         !addr_hit && !start_det && !stop_det) |=> (!sda_oe && state == ST_IDLE));

    // Register writes are only issued while acknowledging a data byte
    assert_write_in_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_RX_ACK && byte_num >= BW'(DATA_POS)));

    // A master NACK releases the data line
    assert_nack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK && scl_rise && sda_f && !start_det && !stop_det) |=> !sda_oe);

endmodule

// File: rtl/clkctl_reg_bank.sv
// Module: clock-control register storage and read mux.
// Stores only writable bits; straps and the PCI-run AND are merged on read.
// Assumes write strobes arrive already range-checked.
module clkctl_reg_bank
    import clkctl_pkg::*;
#(
    localparam int IW = $clog2(REG_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    input  logic [1:0]    fs_strap,
    input  logic          pci_stop_n,
    output logic          spread_en,
    output logic          pd_tristate,
    output logic          alt_freq_sel,
    output logic          pci_run,
    output logic          stop_tristate,
    output logic [1:0]    free_run,
    output logic [1:0]    ch_en,
    output logic [7:0]    aux_ctrl
);
    logic [REG_BYTES-1:0][7:0] store_q;

    // Capture writable bits of the addressed byte; reserved bits stay zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < REG_BYTES; b++) begin
                store_q[b] <= RST_VAL[b];
            end
        end else if (wr_en) begin
            for (int b = 0; b < REG_BYTES; b++) begin
                if (wr_idx == IW'(b)) begin
                    store_q[b] <= wr_data & RW_MASK[b];
                end
            end
        end
    end

    assign pci_run       = store_q[0][1] & pci_stop_n;
    assign spread_en     = store_q[0][7];
    assign pd_tristate   = store_q[0][6];
    assign alt_freq_sel  = store_q[0][5];
    assign stop_tristate = store_q[1][6];
    assign free_run      = store_q[1][5:4];
    assign ch_en         = store_q[1][2:1];
    assign aux_ctrl      = store_q[2];

    // Read mux: stored byte with live strap and combined run bit on byte 0
    always_comb begin
        rd_data = 8'h00;
        if (rd_idx < IW'(REG_BYTES)) begin
            rd_data = store_q[rd_idx];
        end
        if (rd_idx == '0) begin
            rd_data[3:2] = fs_strap;
            rd_data[1]   = pci_run;
        end
    end

    // Run output can only be high while the external stop pin is inactive
    assert_pci_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pci_run |-> pci_stop_n);

    // Without a write strobe the stored bytes hold
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(store_q));

endmodule

// File: rtl/clkctl_smbus_slave.sv
// Module: top of the serial clock-control register slave.
// Wires the bus conditioner, the protocol engine and the register bank.
// Assumes SCL period of many system clocks (well above 2*FILTER_LEN+6).
module clkctl_smbus_slave
    import clkctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7  = 7'h69,
    parameter int         FILTER_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [1:0] fs_strap,
    input  logic       pci_stop_n,
    output logic       spread_en,
    output logic       pd_tristate,
    output logic       alt_freq_sel,
    output logic       pci_run,
    output logic       stop_tristate,
    output logic [1:0] free_run,
    output logic [1:0] ch_en,
    output logic [7:0] aux_ctrl,
    output logic [7:0] byte_count_q
);
    localparam int IW = $clog2(REG_BYTES);

    logic          sda_f;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [7:0]    wr_data;
    logic [IW-1:0] rd_idx;
    logic [7:0]    rd_data;

    clkctl_bus_cond #(.FILT_LEN(FILTER_LEN)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkctl_serial_engine #(
        .DEV_ADDR7 (DEV_ADDR7),
        .NUM_BYTES (REG_BYTES),
        .FILL_BYTE (8'hFF)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .count_q   (byte_count_q)
    );

    clkctl_reg_bank u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_data       (wr_data),
        .rd_idx        (rd_idx),
        .rd_data       (rd_data),
        .fs_strap      (fs_strap),
        .pci_stop_n    (pci_stop_n),
        .spread_en     (spread_en),
        .pd_tristate   (pd_tristate),
        .alt_freq_sel  (alt_freq_sel),
        .pci_run       (pci_run),
        .stop_tristate (stop_tristate),
        .free_run      (free_run),
        .ch_en         (ch_en),
        .aux_ctrl      (aux_ctrl)
    );

endmodule

// File: tb/clkctl_smbus_slave_test.sv
module clkctl_smbus_slave_test;

    localparam int HP = 16;
    localparam int NV = 5;
    // {w0, w1, w2, pins{5'b0, fs[1:0], pci_stop_n}, exp0, exp1, exp2}
    localparam logic [55:0] VEC [NV] = '{
        {8'hFF, 8'hFF, 8'hFF, 8'h07, 8'hEE, 8'h76, 8'hFF},
        {8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00},
        {8'hA5, 8'h5A, 8'h3C, 8'h04, 8'hA8, 8'h52, 8'h3C},
        {8'hC2, 8'h24, 8'h81, 8'h03, 8'hC6, 8'h24, 8'h81},
        {8'h22, 8'h02, 8'h00, 8'h02, 8'h24, 8'h02, 8'h00}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [1:0] fs = 2'b10;
    logic       pci_n = 1'b1;
    logic       sda_line;
    logic       sda_oe, spread_en, pd_tristate, alt_freq_sel, pci_run, stop_tristate;
    logic [1:0] free_run, ch_en;
    logic [7:0] aux_ctrl, byte_count_q;

    assign sda_line = ~(m_low | sda_oe);

    clkctl_smbus_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .fs_strap(fs), .pci_stop_n(pci_n), .spread_en(spread_en),
        .pd_tristate(pd_tristate), .alt_freq_sel(alt_freq_sel), .pci_run(pci_run),
        .stop_tristate(stop_tristate), .free_run(free_run), .ch_en(ch_en),
        .aux_ctrl(aux_ctrl), .byte_count_q(byte_count_q)
    );

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [7:0] wbuf [8];
    logic       wack [8];
    logic [7:0] rbuf [8];
    logic [7:0] rcount;
    logic       ack_a, ack_c, ack_n;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; cyc(HP/2);
        scl = 1'b1;   cyc(HP);
        m_low = 1'b1; cyc(HP);
        scl = 1'b0;   cyc(HP/2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; cyc(HP/2);
        scl = 1'b1;   cyc(HP);
        m_low = 1'b0; cyc(HP);
    endtask

    task automatic put_bit(input logic b, input bit glitch);
        m_low = ~b; cyc(HP/2);
        scl = 1'b1;
        if (glitch) begin
            cyc(HP/2); scl = 1'b0; cyc(1); scl = 1'b1; cyc(HP/2 - 1);
        end else begin
            cyc(HP);
        end
        scl = 1'b0; cyc(HP/2);
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; cyc(HP/2);
        scl = 1'b1;   cyc(HP/2);
        b = sda_line; cyc(HP/2);
        scl = 1'b0;   cyc(HP/2);
    endtask

    task automatic put_byte(input logic [7:0] v, input int gbit, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i], i == gbit);
        get_bit(a);
        ack = ~a;
    endtask

    task automatic get_byte(output logic [7:0] v, input bit last);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(last, 1'b0);
    endtask

    task automatic wr_txn(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] cnt,
                          input int n, input int gbyte, input int gbit);
        bus_start();
        put_byte(addr, -1, ack_a);
        put_byte(cmd, -1, ack_c);
        put_byte(cnt, -1, ack_n);
        for (int k = 0; k < n; k++) put_byte(wbuf[k], (k == gbyte) ? gbit : -1, wack[k]);
        bus_stop();
        cyc(HP);
    endtask

    task automatic rd_txn(input int n);
        logic a;
        bus_start();
        put_byte(8'hD3, -1, a);
        chk("R1 read address ack", {7'b0, a}, 8'h01);
        get_byte(rcount, n == 0);
        for (int k = 0; k < n; k++) get_byte(rbuf[k], k == n - 1);
        chk("R5 line released after NACK", {7'b0, sda_oe}, 8'h00);
        bus_stop();
        cyc(HP);
    endtask

    task automatic read3(input string tag, input logic [7:0] e0, input logic [7:0] e1,
                         input logic [7:0] e2);
        rd_txn(3);
        chk({tag, " count byte R5"}, rcount, 8'h03);
        chk({tag, " byte0"}, rbuf[0], e0);
        chk({tag, " byte1"}, rbuf[1], e1);
        chk({tag, " byte2"}, rbuf[2], e2);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(10);

        // R9 reset state at the ports
        chk("R9 reset spread_en", {7'b0, spread_en}, 8'h00);
        chk("R9 reset ch_en", {6'b0, ch_en}, 8'h03);
        chk("R9 reset pci_run", {7'b0, pci_run}, 8'h01);
        chk("R9 reset aux_ctrl", aux_ctrl, 8'h00);
        chk("R4 reset byte_count_q", byte_count_q, 8'h00);
        chk("R5 reset sda_oe", {7'b0, sda_oe}, 8'h00);
        read3("R9 reset read R6", 8'h0A, 8'h06, 8'h00);

        // Vector table: R3 R6 R7 R8 write/read-back under varied pins
        for (int v = 0; v < NV; v++) begin
            logic [55:0] e;
            e = VEC[v];
            wbuf[0] = e[55:48]; wbuf[1] = e[47:40]; wbuf[2] = e[39:32];
            fs = e[26:25]; pci_n = e[24];
            wr_txn(8'hD2, 8'h00, 8'h03, 3, -1, -1);
            chk("R1 write address ack", {7'b0, ack_a}, 8'h01);
            chk("R2 command and count ack", {6'b0, ack_c, ack_n}, 8'h03);
            for (int k = 0; k < 3; k++) chk("R3 data ack", {7'b0, wack[k]}, 8'h01);
            read3("R3 R6 R7 R8 vector", e[23:16], e[15:8], e[7:0]);
            chk("R7 pci_run pin", {7'b0, pci_run}, {7'b0, e[17]});
            chk("R9 spread_en pin", {7'b0, spread_en}, {7'b0, e[23]});
            chk("R9 ch_en pins", {6'b0, ch_en}, {6'b0, e[10:9]});
            chk("R9 free_run pins", {6'b0, free_run}, {6'b0, e[13:12]});
            chk("R9 aux_ctrl pins", aux_ctrl, e[7:0]);
        end

        // R1 wrong address (one bit away) is ignored entirely
        fs = 2'b00; pci_n = 1'b1;
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
        wr_txn(8'hD0, 8'h00, 8'h03, 3, -1, -1);
        chk("R1 foreign address nack", {7'b0, ack_a}, 8'h00);
        chk("R1 later bytes nack", {6'b0, ack_c, wack[0]}, 8'h00);
        read3("R1 registers unchanged", 8'h22, 8'h02, 8'h00);

        // R2 command byte value does not steer data
        wbuf[0] = 8'h81; wbuf[1] = 8'h00; wbuf[2] = 8'h5A;
        wr_txn(8'hD2, 8'h55, 8'h03, 3, -1, -1);
        chk("R2 odd command ack", {6'b0, ack_c, ack_n}, 8'h03);
        read3("R2 command ignored", 8'h80, 8'h00, 8'h5A);

        // R4 extra bytes acked and discarded, count captured
        wbuf[0] = 8'h40; wbuf[1] = 8'h04; wbuf[2] = 8'h11; wbuf[3] = 8'hEE; wbuf[4] = 8'h77;
        wr_txn(8'hD2, 8'h00, 8'h05, 5, -1, -1);
        chk("R4 fourth byte ack", {7'b0, wack[3]}, 8'h01);
        chk("R4 fifth byte ack", {7'b0, wack[4]}, 8'h01);
        chk("R4 byte_count_q", byte_count_q, 8'h05);
        read3("R4 extra bytes discarded", 8'h40, 8'h04, 8'h11);

        // R9 partial write keeps the untouched bytes
        wbuf[0] = 8'hE0;
        wr_txn(8'hD2, 8'h00, 8'h01, 1, -1, -1);
        read3("R9 retention", 8'hE0, 8'h04, 8'h11);

        // R5 read past the map pads with 0xFF
        rd_txn(5);
        chk("R5 pad byte 4", rbuf[3], 8'hFF);
        chk("R5 pad byte 5", rbuf[4], 8'hFF);

        // R6 strap change without any write
        fs = 2'b11;
        read3("R6 live straps", 8'hEC, 8'h04, 8'h11);

        // R10 one-clock SCL dip inside a data bit
        wbuf[0] = 8'h80; wbuf[1] = 8'h06; wbuf[2] = 8'hC3;
        wr_txn(8'hD2, 8'h00, 8'h03, 3, 0, 6);
        chk("R10 glitched byte ack", {7'b0, wack[0]}, 8'h01);
        read3("R10 glitch filtered", 8'h8C, 8'h06, 8'hC3);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule